// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K words by 16 bits. The host raises a request with a word address, a read/write flag, write data and a per-byte mask. The controller turns each request into the memory's pin sequence: two chip selects of opposite polarity, a write strobe, an output enable, one active-low enable per byte lane, and a data bus split into output, output-enable and input halves so a pad tristate can be placed at the chip edge.

The memory has no clock, so access time is met by counting whole system-clock cycles. The read and write wait counts are derived from picosecond parameters, rounded up to full clock periods. Every memory pin comes straight from a flop. When no access is in progress the memory is deselected with both byte lanes disabled, which keeps it in standby. When a write follows a read, the controller inserts an extra bus-turnaround cycle before it drives the data bus.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever `host_ready` is high, the pins rest in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_be_n`=2'b11, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: A request is taken on a rising edge where `host_req` and `host_ready` are both high. `host_ready` is low in the next cycle and stays low until the access ends. Address, data, mask and flag are used only as sampled at that edge.
- R3: For a read, the cycles that follow acceptance keep the memory selected (`mem_ce1_n`=0, `mem_ce2`=1), with `mem_oe_n`=0, `mem_we_n`=1 and the accepted address. `mem_be_n[0]` is the inverse of mask bit 0 (lane bits 7:0) and `mem_be_n[1]` is the inverse of mask bit 1 (bits 15:8).
- R4: Read data is sampled from `mem_dq_i` at the edge that closes the last wait cycle. `host_rvalid` is then high for exactly one cycle, starting RD_WAIT edges after the acceptance edge. Lanes whose mask bit is 0 are returned as zero.
- R5: A write is one setup cycle (selected, `mem_we_n`=1, data driven), then WR_WAIT cycles with `mem_we_n`=0, then one hold cycle with `mem_we_n`=1 and the memory still selected. Address, byte enables and `mem_dq_o` do not change across the whole sequence, and `mem_dq_oe` is high throughout.
- R6: A write changes only the lanes whose mask bit is 1. A write with mask 2'b00 leaves the word unchanged.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low. A write taken right after a read leaves at least two cycles with `mem_oe_n` high and `mem_dq_oe` low before the controller drives the bus.
- R8: RD_WAIT = ceil(READ_ACCESS_PS / CLK_PERIOD_PS) and WR_WAIT = ceil(WRITE_PULSE_PS / CLK_PERIOD_PS), each at least 1. With the default parameters these give 3 and 2.
- R9: `mem_we_n` is low only while the memory is selected and the controller is driving the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request valid |
| host_ready | output | 1 | Controller can take a request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_rdata | output | 16 | Read data, unselected lanes zero |
| host_rvalid | output | 1 | One-cycle strobe for host_rdata |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte lane enables, active low |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data bus as seen at the pads |

## Verification
The assertions assume that the host holds its request fields steady only up to the acceptance edge, and that `mem_dq_i` carries valid memory data by the edge that closes the last read wait cycle. The bench meets the second assumption with a memory model that returns garbage until the read pins have been stable for the required number of cycles. It also returns junk on disabled lanes and counts write-pulse length, setup and hold violations. The stimulus scrambles the host fields right after each acceptance. Random operations draw from a small address pool that includes address zero and the top address, so that read-backs hit written words, with read-then-write pairs issued back to back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } phase_t;

  // whole clock periods covering a span, never less than one
  function automatic int unsigned cycles_for(input int unsigned span_ps,
                                             input int unsigned clk_ps);
    int unsigned n;
    n = (span_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R8: once counting, the value only falls by one per cycle
  a_r8_steady_countdown: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT = 3,
  parameter int WR_WAIT = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   host_req,
  input  logic   host_we,
  output logic   accept,
  output logic   capture,
  output logic   ready_q,
  output phase_t state_q,
  output phase_t state_d
);

  localparam int MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             last_rd_q;
  logic             tmr_load;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_val;

  assign accept = host_req && ready_q;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (host_we) begin
            state_d = last_rd_q ? ST_TURN : ST_WSETUP;
          end else begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_WAIT - 1);
          end
        end
      end
      ST_TURN:   state_d = ST_WSETUP;
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WR_WAIT - 1);
      end
      ST_WPULSE: if (tmr_done) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      ST_READ: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
          capture = 1'b1;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ready_q   <= 1'b1;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_IDLE);
      if (capture) begin
        last_rd_q <= 1'b1;
      end else if (accept) begin
        last_rd_q <= 1'b0;
      end
    end
  end

  // R2: the controller is busy right after it takes a request
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ready_q);

  // R7: a write taken just after a read always detours through the turn cycle
  a_r7_turn_after_read: assert property (@(posedge clk) disable iff (rst)
    (accept && host_we && last_rd_q) |=> (state_q == ST_TURN));

endmodule

// File: rtl/sram_ctrl_pins.sv
`timescale 1ns/1ps
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_mask,
  input  phase_t            state_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);

  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  cur_mask;
  logic [DATA_W-1:0] lane_keep;

  assign cur_mask = accept ? host_mask : mask_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_keep[g*8 +: 8] = {8{mask_q[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '0;
      mem_addr    <= '0;
      mem_dq_o    <= '0;
      mem_ce1_n   <= 1'b1;
      mem_ce2     <= 1'b0;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_be_n    <= '1;
      mem_dq_oe   <= 1'b0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      if (accept) begin
        mask_q   <= host_mask;
        mem_addr <= host_addr;
        if (host_we) mem_dq_o <= host_wdata;
      end
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_oe <= 1'b0;
      case (state_d)
        ST_READ: begin
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
          mem_oe_n  <= 1'b0;
          mem_be_n  <= ~cur_mask;
        end
        ST_WSETUP, ST_WHOLD: begin
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
          mem_be_n  <= ~cur_mask;
          mem_dq_oe <= 1'b1;
        end
        ST_WPULSE: begin
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
          mem_be_n  <= ~cur_mask;
          mem_dq_oe <= 1'b1;
          mem_we_n  <= 1'b0;
        end
        default: ;
      endcase
      host_rvalid <= capture;
      if (capture) host_rdata <= mem_dq_i & lane_keep;
    end
  end

  // R7: never fight the memory's output drivers
  a_r7_no_drive_while_reading: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  // R7: the cycle after output enable returns high is still undriven
  a_r7_quiet_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> !mem_dq_oe);

  // R9: strobe only while selected and driving
  a_r9_write_only_selected: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe));

  // R5: nothing moves while the strobe is low
  a_r5_stable_in_pulse: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_o)));

  // R5: address, lanes and data were already set up when the strobe falls
  a_r5_setup_before_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |->
      ($stable(mem_addr) && $stable(mem_be_n) && $past(mem_dq_oe) && $past(!mem_ce1_n)));

  // R5: one hold cycle follows the strobe
  a_r5_hold_after_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |->
      (mem_dq_oe && !mem_ce1_n && mem_ce2 && $stable(mem_addr) && $stable(mem_dq_o)));

  // R4: valid strobe is a single-cycle pulse
  a_r4_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  // R3: output enable only appears in a proper read
  a_r3_read_pins: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 19,
  parameter int DATA_W          = 16,
  parameter int CLK_PERIOD_PS   = 20000,
  parameter int READ_ACCESS_PS  = 55000,
  parameter int WRITE_PULSE_PS  = 40000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_req,
  output logic                  host_ready,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]     host_wdata,
  input  logic [DATA_W/8-1:0]   host_mask,
  output logic [DATA_W-1:0]     host_rdata,
  output logic                  host_rvalid,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce1_n,
  output logic                  mem_ce2,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);

  localparam int LANES   = DATA_W / 8;
  localparam int RD_WAIT = int'(cycles_for(READ_ACCESS_PS, CLK_PERIOD_PS));
  localparam int WR_WAIT = int'(cycles_for(WRITE_PULSE_PS, CLK_PERIOD_PS));

  logic   accept;
  logic   capture;
  phase_t state_q;
  phase_t state_d;

  sram_ctrl_fsm #(
    .RD_WAIT (RD_WAIT),
    .WR_WAIT (WR_WAIT)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .host_req (host_req),
    .host_we  (host_we),
    .accept   (accept),
    .capture  (capture),
    .ready_q  (host_ready),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  sram_ctrl_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_pins (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_mask   (host_mask),
    .state_d     (state_d),
    .capture     (capture),
    .mem_dq_i    (mem_dq_i),
    .mem_addr    (mem_addr),
    .mem_ce1_n   (mem_ce1_n),
    .mem_ce2     (mem_ce2),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_be_n    (mem_be_n),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe   (mem_dq_oe),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  // R1: standby whenever the controller is free
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_ce1_n && !mem_ce2 && (mem_be_n == '1) &&
                    mem_we_n && mem_oe_n && !mem_dq_oe));

  // R4: read data only reaches the host when the controller was busy
  a_r4_rvalid_after_busy: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> !$past(host_ready));

endmodule

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;

  localparam int CLK_PS  = 20000;
  localparam int RD_PS   = 55000;
  localparam int WR_PS   = 40000;
  localparam int RD_WAIT = (RD_PS + CLK_PS - 1) / CLK_PS;
  localparam int WR_WAIT = (WR_PS + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [18:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_mask = '0;
  logic        host_ready, host_rvalid;
  logic [15:0] host_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o, mem_dq_i, model_q;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sram_ctrl uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_mask(host_mask), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  assign mem_dq_i = mem_dq_oe ? mem_dq_o : model_q;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [int];
  logic [15:0] expm [int];

  function automatic logic [15:0] mget(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] eget(input int a);
    return expm.exists(a) ? expm[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] lanes16(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  wire sel     = !mem_ce1_n && mem_ce2;
  wire rd_cond = sel && !mem_oe_n && mem_we_n;

  int          rd_cnt = 0;
  logic        p_rd = 0, p_sel = 0, p_dqoe = 0, p_we_n = 1;
  logic [18:0] p_addr = '0;
  logic [1:0]  p_be = '1;
  int          wlow = 0;
  logic [18:0] waddr;
  logic [1:0]  wbe;
  logic [15:0] wdat;
  int setup_bad = 0, stable_bad = 0, len_bad = 0, hold_bad = 0, stray_bad = 0, wr_seen = 0;

  always @* begin
    logic [15:0] v;
    model_q = 16'hA5A5;
    if (rd_cond) begin
      v = (rd_cnt >= RD_WAIT - 1) ? mget(int'(mem_addr)) : 16'hDEAD;
      if (!mem_be_n[0]) model_q[7:0]  = v[7:0];
      if (!mem_be_n[1]) model_q[15:8] = v[15:8];
    end
  end

  always @(posedge clk) begin
    logic [15:0] cur;
    if (rd_cond && p_rd && mem_addr == p_addr && mem_be_n == p_be) rd_cnt <= rd_cnt + 1;
    else if (rd_cond) rd_cnt <= 1;
    else rd_cnt <= 0;
    if (!rst && sel && !mem_we_n) begin
      if (wlow == 0) begin
        waddr <= mem_addr;
        wbe   <= mem_be_n;
        if (!(p_sel && p_dqoe && p_we_n && p_addr == mem_addr && p_be == mem_be_n)) setup_bad++;
      end else if (mem_addr != waddr || mem_be_n != wbe) begin
        stable_bad++;
      end
      wdat <= mem_dq_i;
      wlow <= wlow + 1;
    end else if (wlow != 0) begin
      wr_seen++;
      if (wlow != WR_WAIT) len_bad++;
      if (!(sel && mem_dq_oe && mem_addr == waddr && mem_dq_i == wdat)) hold_bad++;
      cur = mget(int'(waddr));
      if (!wbe[0]) cur[7:0]  = wdat[7:0];
      if (!wbe[1]) cur[15:8] = wdat[15:8];
      mem[int'(waddr)] = cur;
      wlow <= 0;
    end
    if (!rst && !mem_we_n && !sel) stray_bad++;
    p_rd <= rd_cond; p_sel <= sel; p_dqoe <= mem_dq_oe; p_we_n <= mem_we_n;
    p_addr <= mem_addr; p_be <= mem_be_n;
  end

  // ---------------- negedge pin monitor ----------------
  int idle_bad = 0, clash_bad = 0, turn_bad = 0, turn_seen = 0, rv_bad = 0, gap = 0;
  bit after_rd = 0, prev_rv = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (host_ready && !(mem_ce1_n && !mem_ce2 && mem_be_n == 2'b11 && mem_we_n &&
                          mem_oe_n && !mem_dq_oe)) idle_bad++;
      if (mem_dq_oe && !mem_oe_n) clash_bad++;
      if (!mem_oe_n) begin
        gap = 0; after_rd = 1;
      end else if (!mem_dq_oe) begin
        gap++;
      end else if (after_rd) begin
        turn_seen++;
        if (gap < 2) turn_bad++;
        after_rd = 0;
      end
      if (host_rvalid && prev_rv) rv_bad++;
      prev_rv = host_rvalid;
    end
  end

  // ---------------- host tasks ----------------
  task automatic wait_accept();
    bit acc;
    do begin
      acc = host_ready;
      @(negedge clk);
    end while (!acc);
  endtask

  task automatic scramble();
    host_req   = 1'b0;
    host_addr  = 19'($urandom);
    host_wdata = 16'($urandom);
    host_mask  = 2'($urandom);
    host_we    = 1'($urandom);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] cur;
    int n;
    host_we = 1'b1; host_addr = a; host_wdata = d; host_mask = m; host_req = 1'b1;
    wait_accept();
    scramble();
    check(host_ready == 1'b0, "R2", "ready low after write accept", 32'(host_ready), 0);
    cur = eget(int'(a));
    cur = (cur & ~lanes16(m)) | (d & lanes16(m));
    expm[int'(a)] = cur;
    n = 0;
    while (!host_ready && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_read(input logic [18:0] a, input logic [1:0] m);
    logic [15:0] exp;
    int n;
    bit pins_ok;
    host_we = 1'b0; host_addr = a; host_mask = m; host_req = 1'b1;
    wait_accept();
    scramble();
    n = 0;
    pins_ok = 1;
    while (!host_rvalid && n < 50) begin
      if (!(sel && !mem_oe_n && mem_we_n && mem_addr == a && mem_be_n == ~m)) pins_ok = 0;
      @(negedge clk);
      n++;
    end
    exp = eget(int'(a)) & lanes16(m);
    check(pins_ok, "R3", "read pin levels", {13'd0, mem_addr}, {13'd0, a});
    check(n == RD_WAIT, "R4", "rvalid latency (R8 wait count)", 32'(n), 32'(RD_WAIT));
    check(host_rdata == exp, "R4", "read data, unselected lanes zero", 32'(host_rdata), 32'(exp));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main ----------------
  logic [18:0] pool [16];

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) pool[i] = 19'($urandom);
    pool[0]  = 19'h00000;
    pool[15] = 19'h7FFFF;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mem_ce1_n == 1 && mem_ce2 == 0 && mem_be_n == 2'b11 && mem_we_n == 1 &&
          mem_oe_n == 1 && mem_dq_oe == 0 && host_ready == 1,
          "R1", "standby pins after reset",
          {25'd0, mem_ce1_n, mem_ce2, mem_be_n, mem_we_n, mem_oe_n, mem_dq_oe},
          {25'd0, 7'b1011110});

    do_read(pool[3], 2'b11);                      // R4 unwritten word
    do_write(pool[1], 16'h1234, 2'b11);           // R5
    do_read(pool[1], 2'b11);
    do_write(pool[1], 16'hFFFF, 2'b01);           // R6 low lane only
    do_read(pool[1], 2'b11);
    check(host_rdata == 16'h12FF, "R6", "low-lane write", 32'(host_rdata), 32'h12FF);
    do_read(pool[1], 2'b10);                      // R4 low lane returned zero
    check(host_rdata == 16'h1200, "R4", "masked low lane", 32'(host_rdata), 32'h1200);
    do_write(pool[1], 16'h0000, 2'b00);           // R6 no lanes
    do_read(pool[1], 2'b11);
    check(host_rdata == 16'h12FF, "R6", "empty-mask write keeps word", 32'(host_rdata), 32'h12FF);
    do_write(pool[15], 16'hBEEF, 2'b10);          // top address, high lane
    do_read(pool[15], 2'b11);
    do_read(pool[1], 2'b01);                      // R7 read then write back to back
    do_write(pool[0], 16'hCAFE, 2'b11);
    do_read(pool[0], 2'b11);

    for (int i = 0; i < 400; i++) begin
      logic [18:0] a;
      a = pool[$urandom_range(15)];
      repeat ($urandom_range(2)) @(negedge clk);
      if ($urandom_range(1) == 1) do_write(a, 16'($urandom), 2'($urandom));
      else do_read(a, 2'($urandom));
      if ($urandom_range(7) == 0) begin
        do_read(a, 2'b11);
        do_write(a, 16'($urandom), 2'($urandom));
      end
    end
    repeat (4) @(negedge clk);

    check(idle_bad == 0, "R1", "standby while ready", 32'(idle_bad), 0);
    check(clash_bad == 0, "R7", "drive while output enabled", 32'(clash_bad), 0);
    check(turn_bad == 0 && turn_seen > 0, "R7", "turnaround gap violations", 32'(turn_bad), 0);
    check(rv_bad == 0, "R4", "rvalid wider than one cycle", 32'(rv_bad), 0);
    check(len_bad == 0 && wr_seen > 0, "R5", "write pulse length (R8 wait count)", 32'(len_bad), 0);
    check(setup_bad == 0, "R5", "setup cycle before strobe", 32'(setup_bad), 0);
    check(stable_bad == 0, "R5", "address/lanes moved in pulse", 32'(stable_bad), 0);
    check(hold_bad == 0, "R5", "hold cycle after strobe", 32'(hold_bad), 0);
    check(stray_bad == 0, "R9", "strobe while deselected", 32'(stray_bad), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule